// File: doc/BRIEF.md
# Inclusive Last-Level Cache Directory Controller

This block holds the tags and per-core presence flags of a shared last-level cache that serves four cores. Each core has its own private caches. Each core sends read or read-for-ownership requests. The block picks one request at a time and looks up a set-associative tag array. It then decides which cores, if any, must be contacted before the requester gets its answer. The shared level is inclusive: every line held privately by a core is also valid here. Because of that, a lookup that misses can go straight to memory without asking any core. A lookup that hits contacts only the cores whose presence flag is set on that line, never all of them.

When a miss needs a way, the block chooses a victim. It takes the lowest-numbered invalid way if there is one, and otherwise uses a tree pseudo-LRU. If the victim line is still flagged in some cores, the block invalidates those copies and waits for their acknowledgements before it issues the memory read. This keeps inclusion intact. The data array, the memory controller and any clock crossing sit outside this block.

Top module: `sf_snoop_filter`

## Requirements
- R1: After reset is released, the block sweeps the array and clears every valid bit and presence flag, one set per clock. `req_ready` stays low for SETS clock edges, and the first request is taken on the cycle after the sweep ends.
- R2: A request address is split into a set index in the low log2(SETS) bits and a tag in the remaining bits. On a miss, `mem_req` is raised with `mem_addr` equal to the request address, and no snoop is sent. After `mem_fill`, the core gets a response with `rsp_hit`=0.
- R3: On a read hit, `snp_valid` is the line's presence vector with the requester's bit removed, and `snp_inv`=0 (the copy is shared). If that vector is empty, no snoop is sent and the response follows directly with `rsp_hit`=1.
- R4: Each `snp_valid` bit stays high until the matching `snp_ack` bit arrives. `rsp_valid` is never raised while any snoop bit is still pending.
- R5: When a miss is filled or a hit is answered, the requester's presence bit is set on the line.
- R6: On a read-for-ownership hit, the other flagged cores get snoops with `snp_inv`=1. Once they have all acknowledged, the presence vector holds only the requester's bit.
- R7: The victim on a miss is the lowest invalid way. If every way is valid, the victim comes from a per-set pseudo-LRU tree of WAYS-1 bits. In that tree a 0 sends the search toward the lower-numbered half. Every hit and every fill turns the path bits away from the way that was touched.
- R8: If a valid victim has any presence bit set, those cores get snoops with `snp_inv`=1 and `snp_addr` equal to the victim's address. The memory read starts only after all of them acknowledge, and the victim's flags are then gone.
- R9: The round-robin arbiter starts its search at the core after the one granted last, with core 3 wrapping to core 0.
- R10: Only one request is in flight at a time. At most one `req_ready` bit is high, and it is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 4 | Request pending, one bit per core |
| req_rfo | input | 4 | 1 = read-for-ownership, 0 = plain read, per core |
| req_addr | input | 4*AW | Line address per core, core k in bits [k*AW +: AW] |
| req_ready | output | 4 | One-cycle accept strobe to the granted core |
| rsp_valid | output | 1 | Response strobe |
| rsp_core | output | 2 | Core that receives the response |
| rsp_hit | output | 1 | 1 = line was present in the shared cache |
| snp_valid | output | 4 | Snoop outstanding to each core |
| snp_inv | output | 1 | 1 = invalidate, 0 = keep a shared copy |
| snp_addr | output | AW | Line address being snooped |
| snp_ack | input | 4 | Snoop acknowledge pulse per core |
| mem_req | output | 1 | Memory read outstanding |
| mem_addr | output | AW | Address of the memory read |
| mem_fill | input | 1 | Memory data returned pulse |

## Verification
A request accepted at a clock edge is looked up on the next edge. A response to a hit with no snoop appears one edge later. A miss raises `mem_req` on that same edge, and its response appears on the edge after `mem_fill` is seen. A snoop phase ends on the edge that takes the last acknowledge, and the response follows on the next cycle. Because these delays change with snoop and fill timing, the bench does not count fixed cycles. It queues the expected snoop vectors, memory addresses and responses in order. Responder and monitor processes sample on falling edges and compare each event as it appears. A response seen while snoops are still pending is reported as an error.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int NCORE = 4;
  localparam int CW    = 2;
  typedef logic [NCORE-1:0] core_vec_t;
  typedef enum logic [2:0] {
    ST_INIT, ST_IDLE, ST_LOOK, ST_SNP, ST_VICT, ST_MEM, ST_RESP
  } sf_state_e;
endpackage

// File: rtl/sf_rr_arb.sv
module sf_rr_arb #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic [N-1:0]         req,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] gnt_idx
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr_q, ptr_d, cand;
  logic          found;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    cand    = '0;
    for (int k = 0; k < N; k++) begin
      cand = ptr_q + IW'(k);
      if (!found && req[cand]) begin
        found   = 1'b1;
        gnt_idx = cand;
        gnt[cand] = 1'b1;
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = gnt_idx + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R9: a grant always goes to a requesting input
  p_gnt_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |-> (|(gnt & req)));
endmodule

// File: rtl/sf_plru.sv
module sf_plru #(
  parameter int SETS = 16,
  parameter int WAYS = 4
) (
  input  logic                    clk,
  input  logic                    clr_en,
  input  logic [$clog2(SETS)-1:0] clr_set,
  input  logic [$clog2(SETS)-1:0] rd_set,
  output logic [$clog2(WAYS)-1:0] victim,
  input  logic                    touch_en,
  input  logic [$clog2(SETS)-1:0] touch_set,
  input  logic [$clog2(WAYS)-1:0] touch_way
);
  localparam int LW = $clog2(WAYS);
  localparam int NB = WAYS - 1;
  localparam int NW = (NB > 1) ? $clog2(NB) : 1;

  logic [NB-1:0] bits_q [SETS];
  logic [NB-1:0] upd;
  int            node, idx, par;

  always_comb begin
    node = 0;
    for (int l = 0; l < LW; l++)
      node = 2 * node + 1 + int'(bits_q[rd_set][NW'(node)]);
    victim = LW'(node - NB);
  end

  always_comb begin
    upd = bits_q[touch_set];
    idx = int'(touch_way) + NB;
    par = 0;
    for (int l = 0; l < LW; l++) begin
      par = (idx - 1) / 2;
      upd[NW'(par)] = (idx == 2 * par + 1);
      idx = par;
    end
  end

  always_ff @(posedge clk) begin
    if (clr_en)        bits_q[clr_set]   <= '0;
    else if (touch_en) bits_q[touch_set] <= upd;
  end
endmodule

// File: rtl/sf_tag_dir.sv
module sf_tag_dir #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  parameter int TW   = 8
) (
  input  logic                    clk,
  input  logic                    clr_en,
  input  logic [$clog2(SETS)-1:0] clr_set,
  input  logic [$clog2(SETS)-1:0] lk_set,
  input  logic [TW-1:0]           lk_tag,
  output logic [WAYS-1:0]         set_valid,
  output logic                    hit,
  output logic [$clog2(WAYS)-1:0] hit_way,
  output sf_pkg::core_vec_t       hit_pres,
  input  logic [$clog2(WAYS)-1:0] sel_way,
  output logic                    sel_valid,
  output logic [TW-1:0]           sel_tag,
  output sf_pkg::core_vec_t       sel_pres,
  input  logic                    wr_en,
  input  logic [$clog2(WAYS)-1:0] wr_way,
  input  logic                    wr_valid,
  input  logic                    wr_tag_en,
  input  logic [TW-1:0]           wr_tag,
  input  sf_pkg::core_vec_t       wr_pres
);
  localparam int WW = $clog2(WAYS);

  logic [WAYS-1:0]   valid_q [SETS];
  logic [TW-1:0]     tag_q   [SETS][WAYS];
  sf_pkg::core_vec_t pres_q  [SETS][WAYS];

  always_comb begin
    set_valid = valid_q[lk_set];
    hit       = 1'b0;
    hit_way   = '0;
    hit_pres  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid_q[lk_set][w] && tag_q[lk_set][w] == lk_tag && !hit) begin
        hit      = 1'b1;
        hit_way  = WW'(w);
        hit_pres = pres_q[lk_set][w];
      end
    end
    sel_valid = valid_q[lk_set][sel_way];
    sel_tag   = tag_q[lk_set][sel_way];
    sel_pres  = pres_q[lk_set][sel_way];
  end

  always_ff @(posedge clk) begin
    if (clr_en) begin
      valid_q[clr_set] <= '0;
      for (int w = 0; w < WAYS; w++) pres_q[clr_set][w] <= '0;
    end else if (wr_en) begin
      valid_q[lk_set][wr_way] <= wr_valid;
      pres_q[lk_set][wr_way]  <= wr_pres;
      if (wr_tag_en) tag_q[lk_set][wr_way] <= wr_tag;
    end
  end
endmodule

// File: rtl/sf_snoop_filter.sv
module sf_snoop_filter #(
  parameter int AW   = 12,
  parameter int SETS = 16,
  parameter int WAYS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        req_valid,
  input  logic [3:0]        req_rfo,
  input  logic [4*AW-1:0]   req_addr,
  output logic [3:0]        req_ready,
  output logic              rsp_valid,
  output logic [1:0]        rsp_core,
  output logic              rsp_hit,
  output logic [3:0]        snp_valid,
  output logic              snp_inv,
  output logic [AW-1:0]     snp_addr,
  input  logic [3:0]        snp_ack,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_fill
);
  import sf_pkg::*;

  localparam int SW = $clog2(SETS);
  localparam int TW = AW - SW;
  localparam int WW = $clog2(WAYS);

  sf_state_e         state_q, state_d;
  logic [CW-1:0]     core_q, core_d;
  logic              rfo_q, rfo_d, hit_q, hit_d, inv_q, inv_d;
  logic [AW-1:0]     addr_q, addr_d, saddr_q, saddr_d;
  logic [WW-1:0]     way_q, way_d;
  core_vec_t         pend_q, pend_d, req_bit;
  logic [SW-1:0]     cnt_q, cnt_d;

  logic              accept, clr_en;
  logic [3:0]        gnt;
  logic [CW-1:0]     gnt_idx;
  logic [SW-1:0]     lk_set;
  logic [TW-1:0]     lk_tag;
  logic [WAYS-1:0]   set_valid;
  logic              lk_hit, sel_valid;
  logic [WW-1:0]     hit_way, sel_way, plru_vic, vic_way;
  core_vec_t         hit_pres, sel_pres, wr_pres, others;
  logic [TW-1:0]     sel_tag;
  logic              wr_en, wr_valid, wr_tag_en, touch_en;

  assign lk_set  = addr_q[SW-1:0];
  assign lk_tag  = addr_q[AW-1:SW];
  assign req_bit = core_vec_t'(1) << core_q;
  assign others  = hit_pres & ~req_bit;

  sf_rr_arb #(.N(NCORE)) u_arb (
    .clk(clk), .rst_n(rst_n), .adv(accept), .req(req_valid),
    .gnt(gnt), .gnt_idx(gnt_idx)
  );

  sf_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk(clk), .clr_en(clr_en), .clr_set(cnt_q), .rd_set(lk_set),
    .victim(plru_vic), .touch_en(touch_en), .touch_set(lk_set),
    .touch_way(way_q)
  );

  sf_tag_dir #(.SETS(SETS), .WAYS(WAYS), .TW(TW)) u_dir (
    .clk(clk), .clr_en(clr_en), .clr_set(cnt_q),
    .lk_set(lk_set), .lk_tag(lk_tag), .set_valid(set_valid),
    .hit(lk_hit), .hit_way(hit_way), .hit_pres(hit_pres),
    .sel_way(sel_way), .sel_valid(sel_valid), .sel_tag(sel_tag),
    .sel_pres(sel_pres), .wr_en(wr_en), .wr_way(way_q),
    .wr_valid(wr_valid), .wr_tag_en(wr_tag_en), .wr_tag(lk_tag),
    .wr_pres(wr_pres)
  );

  // victim: lowest invalid way, else the tree pick
  always_comb begin
    vic_way = plru_vic;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!set_valid[w]) vic_way = WW'(w);
  end
  assign sel_way = (state_q == ST_LOOK) ? vic_way : way_q;

  always_comb begin
    state_d = state_q;  core_d  = core_q;  rfo_d  = rfo_q;
    addr_d  = addr_q;   saddr_d = saddr_q; way_d  = way_q;
    hit_d   = hit_q;    inv_d   = inv_q;   cnt_d  = cnt_q;
    pend_d  = pend_q & ~snp_ack;
    accept  = 1'b0;  clr_en   = 1'b0;  touch_en  = 1'b0;
    wr_en   = 1'b0;  wr_valid = 1'b0;  wr_tag_en = 1'b0;  wr_pres = '0;
    case (state_q)
      ST_INIT: begin
        clr_en = 1'b1;
        cnt_d  = cnt_q + SW'(1);
        if (cnt_q == SW'(SETS - 1)) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (|req_valid) begin
          accept  = 1'b1;
          core_d  = gnt_idx;
          rfo_d   = req_rfo[gnt_idx];
          addr_d  = req_addr[int'(gnt_idx) * AW +: AW];
          state_d = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (lk_hit) begin
          hit_d   = 1'b1;
          way_d   = hit_way;
          pend_d  = others;
          inv_d   = rfo_q;
          saddr_d = addr_q;
          state_d = (|others) ? ST_SNP : ST_RESP;
        end else begin
          hit_d = 1'b0;
          way_d = vic_way;
          if (sel_valid && (|sel_pres)) begin
            pend_d  = sel_pres;
            inv_d   = 1'b1;
            saddr_d = {sel_tag, lk_set};
            state_d = ST_VICT;
          end else begin
            state_d = ST_MEM;
          end
        end
      end
      ST_SNP: begin
        if (pend_d == '0) state_d = ST_RESP;
      end
      ST_VICT: begin
        if (pend_d == '0) begin
          wr_en   = 1'b1;
          state_d = ST_MEM;
        end
      end
      ST_MEM: begin
        if (mem_fill) begin
          wr_en     = 1'b1;
          wr_valid  = 1'b1;
          wr_tag_en = 1'b1;
          wr_pres   = req_bit;
          touch_en  = 1'b1;
          state_d   = ST_RESP;
        end
      end
      ST_RESP: begin
        if (hit_q) begin
          wr_en    = 1'b1;
          wr_valid = 1'b1;
          wr_pres  = rfo_q ? req_bit : (sel_pres | req_bit);
          touch_en = 1'b1;
        end
        state_d = ST_IDLE;
      end
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;  core_q <= '0;  rfo_q  <= 1'b0;
      addr_q  <= '0;       saddr_q <= '0; way_q  <= '0;
      hit_q   <= 1'b0;     inv_q  <= 1'b0; pend_q <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;  core_q <= core_d;  rfo_q  <= rfo_d;
      addr_q  <= addr_d;   saddr_q <= saddr_d; way_q <= way_d;
      hit_q   <= hit_d;    inv_q  <= inv_d;   pend_q <= pend_d;
      cnt_q   <= cnt_d;
    end
  end

  assign req_ready = accept ? gnt : 4'b0000;
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_core  = core_q;
  assign rsp_hit   = hit_q;
  assign snp_valid = pend_q;
  assign snp_inv   = inv_q;
  assign snp_addr  = saddr_q;
  assign mem_req   = (state_q == ST_MEM);
  assign mem_addr  = addr_q;

  p_init_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INIT) |-> (req_ready == 4'b0000));
  p_miss_no_snoop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (snp_valid == 4'b0000));
  p_hit_excl_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SNP) |-> ((snp_valid & req_bit) == 4'b0000));
  p_rsp_after_acks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (snp_valid == 4'b0000));
  p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));
  p_single_flight_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |=> (req_ready == 4'b0000));

  for (genvar i = 0; i < NCORE; i++) begin : g_hold
    p_snoop_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid[i] && !snp_ack[i]) |=> snp_valid[i]);
  end
endmodule

// File: tb/sim_sf_snoop_filter.sv
module sim_sf_snoop_filter;
  localparam int CLK  = 10;
  localparam int AW   = 12;
  localparam int SETS = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [3:0]      req_valid = '0, req_rfo = '0;
  logic [4*AW-1:0] req_addr = '0;
  logic [3:0]      req_ready, snp_valid;
  logic            rsp_valid, rsp_hit, snp_inv, mem_req;
  logic [1:0]      rsp_core;
  logic [AW-1:0]   snp_addr, mem_addr;
  logic [3:0]      snp_ack = '0;
  logic            mem_fill = 1'b0;

  int checks = 0, errors = 0;
  logic [2:0]  exp_rsp [$];
  logic [16:0] exp_snp [$];
  logic [AW-1:0] exp_mem [$];

  always #(CLK/2) clk = ~clk;

  sf_snoop_filter #(.AW(AW), .SETS(SETS), .WAYS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rfo(req_rfo),
    .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_core(rsp_core), .rsp_hit(rsp_hit), .snp_valid(snp_valid),
    .snp_inv(snp_inv), .snp_addr(snp_addr), .snp_ack(snp_ack),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_fill(mem_fill)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int tag, input int set);
    return {8'(tag), 4'(set)};
  endfunction

  // response monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      chk(snp_valid == 4'b0, "R4 rsp while snoop pending", int'(snp_valid), 0);
      if (exp_rsp.size() == 0) chk(1'b0, "R10 unexpected rsp", int'(rsp_core), -1);
      else begin
        logic [2:0] e;
        e = exp_rsp.pop_front();
        chk({rsp_core, rsp_hit} == e, "R2/R3 rsp core,hit", int'({rsp_core, rsp_hit}), int'(e));
      end
    end
  end

  // snoop responder: check on first sight, then ack one core per cycle
  initial begin
    bit seen = 0;
    forever begin
      @(negedge clk);
      snp_ack = '0;
      if (rst_n && snp_valid != 4'b0) begin
        if (!seen) begin
          seen = 1;
          if (exp_snp.size() == 0) chk(1'b0, "R2 unexpected snoop", int'(snp_valid), 0);
          else begin
            logic [16:0] e;
            e = exp_snp.pop_front();
            chk({snp_valid, snp_inv, snp_addr} == e, "R3/R6/R8 snoop mask,inv,addr",
                int'({snp_valid, snp_inv, snp_addr}), int'(e));
          end
        end else begin
          for (int i = 0; i < 4; i++)
            if (snp_valid[i] && snp_ack == 4'b0) snp_ack[i] = 1'b1;
        end
      end else seen = 0;
    end
  end

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        chk(snp_valid == 4'b0, "R8 memory read before acks", int'(snp_valid), 0);
        if (exp_mem.size() == 0) chk(1'b0, "R2 unexpected mem read", int'(mem_addr), -1);
        else begin
          logic [AW-1:0] e;
          e = exp_mem.pop_front();
          chk(mem_addr == e, "R2 mem_addr", int'(mem_addr), int'(e));
        end
        @(negedge clk);
        mem_fill = 1'b1;
        @(negedge clk);
        mem_fill = 1'b0;
      end
    end
  end

  task automatic drive(input int c, input bit rfo, input logic [AW-1:0] a);
    req_addr[c*AW +: AW] = a;
    req_rfo[c] = rfo;
    req_valid[c] = 1'b1;
    forever begin
      #1;
      if (req_ready[c]) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid[c] = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_rsp.size() != 0 || exp_snp.size() != 0 || exp_mem.size() != 0) && n < 200) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic op(input int c, input bit rfo, input logic [AW-1:0] a,
                    input bit hit, input logic [3:0] smask, input bit sinv,
                    input logic [AW-1:0] saddr);
    exp_rsp.push_back({2'(c), hit});
    if (smask != 0) exp_snp.push_back({smask, sinv, saddr});
    if (!hit) exp_mem.push_back(a);
    drive(c, rfo, a);
    drain();
  endtask

  initial begin
    #(CLK * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] A, B, C, D, E, F, G;
    int waits;
    A = mk(1, 3); B = mk(2, 3); C = mk(3, 3); D = mk(4, 3);
    E = mk(5, 3); F = mk(6, 3); G = mk(11, 3);
    repeat (3) @(negedge clk);
    chk({rsp_valid, mem_req, snp_valid} == 0, "R1 outputs idle in reset",
        int'({rsp_valid, mem_req, snp_valid}), 0);
    req_addr[0 +: AW] = A;
    req_valid[0] = 1'b1;
    exp_rsp.push_back({2'd0, 1'b0});
    exp_mem.push_back(A);
    rst_n = 1'b1;
    waits = 0;
    forever begin
      @(negedge clk); #1;
      waits++;
      if (req_ready[0] || waits > 40) break;
    end
    chk(waits == SETS, "R1 sweep length before first accept", waits, SETS);
    @(negedge clk);
    req_valid[0] = 1'b0;
    drain();                                   // R1/R2: first request misses
    op(1, 0, A, 1, 4'b0001, 0, A);             // R3 read hit snoops core0 only
    op(2, 1, A, 1, 4'b0011, 1, A);             // R6 rfo hit invalidates 0,1
    op(0, 0, A, 1, 4'b0100, 0, A);             // R6 only core2 remained; R5
    op(2, 0, A, 1, 4'b0001, 0, A);             // R3 requester excluded
    op(3, 0, A, 1, 4'b0101, 0, A);             // R4 two acks gathered
    op(1, 0, B, 0, 4'b0000, 0, B);             // R7 invalid ways filled first
    op(1, 0, C, 0, 4'b0000, 0, C);
    op(1, 0, D, 0, 4'b0000, 0, D);
    op(1, 0, E, 0, 4'b1101, 1, A);             // R7 tree picks way0, R8 back-inval
    op(0, 0, B, 1, 4'b0010, 0, B);             // R5 fill flagged core1
    op(3, 0, F, 0, 4'b0010, 1, C);             // R7 tree picks way2 (C)
    op(1, 0, B, 1, 4'b0001, 0, B);             // R3
    op(1, 0, D, 1, 4'b0000, 0, D);             // R3 only requester flagged: no snoop
    // R9: all four at once, last grant was core1 -> order 2,3,0,1
    exp_rsp.push_back({2'd2, 1'b0}); exp_mem.push_back(mk(9, 5));
    exp_rsp.push_back({2'd3, 1'b0}); exp_mem.push_back(mk(10, 5));
    exp_rsp.push_back({2'd0, 1'b0}); exp_mem.push_back(mk(7, 5));
    exp_rsp.push_back({2'd1, 1'b0}); exp_mem.push_back(mk(8, 5));
    fork
      drive(0, 0, mk(7, 5));
      drive(1, 0, mk(8, 5));
      drive(2, 0, mk(9, 5));
      drive(3, 0, mk(10, 5));
    join
    drain();
    op(0, 1, G, 0, 4'b0010, 1, E);             // R7/R8 rfo miss evicts E
    op(1, 0, G, 1, 4'b0001, 0, G);             // R5 rfo fill flagged core0
    chk(exp_rsp.size() == 0, "R10 all responses seen", exp_rsp.size(), 0);
    chk(exp_snp.size() == 0, "R4 all snoops seen", exp_snp.size(), 0);
    chk(exp_mem.size() == 0, "R2 all memory reads seen", exp_mem.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule